// File: doc/BRIEF.md
# Three-Wire Serial Register Loader

The loader takes programming words for a twin frequency synthesizer over three wires: a serial clock, a serial data line and an enable. While enable is high, each rising edge of the serial clock shifts one bit into a 20-bit shift register, most significant bit first. When enable falls, the three bits received last are decoded as an address. The 17 bits above them are written into one of six holding latches: a divider word and a reference word for each synthesizer, and two control words. The latch outputs drive the synthesizer datapaths directly.

All three serial lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and its edges are detected in the system clock domain. The interface does not count bits. If more than 20 bits arrive, the earliest ones simply fall out of the register. A load strobe goes high on the falling edge of enable and stays high until the next falling edge of the serial clock. Reset clears every latch to zero, which leaves both synthesizers powered down, and the interface can still be programmed from that state.

Top module: `ser_loader`

## Requirements
- R1: After reset all six latch outputs are zero and load_o is low.
- R2: A bit is captured only on a rising serial clock edge while enable is high. Serial clock edges while enable is low leave the shift register unchanged.
- R3: Bits enter MSB first. For a frame f[19:0] sent f[19] first, the latch receives f[19:3] and the address is f[2:0].
- R4: Leading bits beyond 20 are discarded, and only the last 20 bits received count.
- R5: The address map is 001 to div1_o, 010 to ref1_o, 011 to div2_o, 100 to ref2_o, 101 to ctrl_a_o and 110 to ctrl_b_o.
- R6: A frame with address 000 or 111 changes no latch.
- R7: Latches change only as a result of a falling enable edge. While bits are being shifted, every output holds its value.
- R8: load_o rises after a falling enable edge and stays high through a rising serial clock edge. It returns low after the next falling serial clock edge.
- R9: A single frame writes at most one latch.
- R10: Programming works straight out of reset, while both control words are zero and so hold both synthesizers in power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sen_i | input | 1 | Serial enable, asynchronous |
| div1_o | output | 17 | Synthesizer 1 main/swallow word |
| ref1_o | output | 17 | Synthesizer 1 reference word |
| div2_o | output | 17 | Synthesizer 2 main/swallow word |
| ref2_o | output | 17 | Synthesizer 2 reference word |
| ctrl_a_o | output | 17 | First control word |
| ctrl_b_o | output | 17 | Second control word |
| load_o | output | 1 | Load strobe, enable fall to next serial clock fall |

## Verification
The assertions check several properties on every cycle. The shift register holds unless a qualified rising edge arrives. At most one latch is written at a time. No latch moves without a falling enable edge, and addresses 000 and 111 write nothing. The load strobe is set and cleared on exactly the right edges. Only the bench scenarios can show the end-to-end properties: bit order, the mapping from each address to its output port, discarding of excess leading bits, and clocks sent while enable is low having no effect on a later frame.

// File: rtl/ser_loader_pkg.sv
package ser_loader_pkg;
  localparam int DATA_W  = 17;
  localparam int ADDR_W  = 3;
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int NUM_REG = 6;  // addresses 1..6
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ser_edge.sv
module ser_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic sen_s_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sen_fall_o
);
  logic sclk_q, sen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sen_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s_i;
      sen_q  <= sen_s_i;
    end
  end

  assign sclk_rise_o = sclk_s_i & ~sclk_q;
  assign sclk_fall_o = ~sclk_s_i & sclk_q;
  assign sen_fall_o  = ~sen_s_i & sen_q;
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               sen_i,
  input  logic               sdata_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] shift_q;

  // no bit counter: older bits fall off the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 shift_q <= '0;
    else if (sclk_rise_i && sen_i) shift_q <= {shift_q[FRAME_W-2:0], sdata_i};
  end

  assign frame_o = shift_q;

  p_hold_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_rise_i && sen_i) |=> $stable(shift_q));
endmodule

// File: rtl/ser_bank.sv
module ser_bank
  import ser_loader_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sen_fall_i,
  input  logic                          sclk_fall_i,
  input  logic [FRAME_W-1:0]            frame_i,
  output logic [NUM_REG-1:0][DATA_W-1:0] regs_o,
  output logic                          load_o
);
  logic [ADDR_W-1:0]           addr;
  logic [DATA_W-1:0]           wdata;
  logic [NUM_REG-1:0]          wr_vec;
  logic [NUM_REG-1:0][DATA_W-1:0] regs_q;
  logic                        load_q;

  assign addr  = frame_i[ADDR_W-1:0];
  assign wdata = frame_i[FRAME_W-1:ADDR_W];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_latch
    assign wr_vec[g] = sen_fall_i && (addr == ADDR_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= '0;
      else if (wr_vec[g]) regs_q[g] <= wdata;
    end
  end

  // strobe: enable fall opens, next serial clock fall closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          load_q <= 1'b0;
    else if (sen_fall_i)  load_q <= 1'b1;
    else if (sclk_fall_i) load_q <= 1'b0;
  end

  assign regs_o = regs_q;
  assign load_o = load_q;

  p_one_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));
  p_no_write_without_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_fall_i |=> $stable(regs_q));
  p_unused_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sen_fall_i && (addr == '0 || addr == '1)) |=> $stable(regs_q));
  p_load_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_fall_i |=> load_q);
  p_load_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && !sclk_fall_i) |=> load_q);
  p_load_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && !sen_fall_i) |=> !load_q);
endmodule

// File: rtl/ser_loader.sv
module ser_loader
  import ser_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_i,
  output logic [DATA_W-1:0] div1_o,
  output logic [DATA_W-1:0] ref1_o,
  output logic [DATA_W-1:0] div2_o,
  output logic [DATA_W-1:0] ref2_o,
  output logic [DATA_W-1:0] ctrl_a_o,
  output logic [DATA_W-1:0] ctrl_b_o,
  output logic              load_o
);
  logic [2:0]                     sync_q;
  logic                           sclk_rise, sclk_fall, sen_fall;
  logic [FRAME_W-1:0]             frame;
  logic [NUM_REG-1:0][DATA_W-1:0] regs;

  ser_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, sdata_i, sen_i}), .q_o(sync_q)
  );

  ser_edge u_edge (
    .clk_i, .rst_ni, .sclk_s_i(sync_q[2]), .sen_s_i(sync_q[0]),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .sen_fall_o(sen_fall)
  );

  ser_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni, .sclk_rise_i(sclk_rise), .sen_i(sync_q[0]),
    .sdata_i(sync_q[1]), .frame_o(frame)
  );

  ser_bank u_bank (
    .clk_i, .rst_ni, .sen_fall_i(sen_fall), .sclk_fall_i(sclk_fall),
    .frame_i(frame), .regs_o(regs), .load_o(load_o)
  );

  assign div1_o   = regs[0];
  assign ref1_o   = regs[1];
  assign div2_o   = regs[2];
  assign ref2_o   = regs[3];
  assign ctrl_a_o = regs[4];
  assign ctrl_b_o = regs[5];
endmodule

// File: tb/ser_loader_tb_top.sv
module ser_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen = 1'b0;
  logic [16:0] div1, ref1, div2, ref2, ctla, ctlb;
  logic load;

  int errors = 0, checks = 0, cyc = 0;
  logic done = 1'b0;
  logic [16:0] expv [6];

  always #5 clk = ~clk;

  ser_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .div1_o(div1), .ref1_o(ref1), .div2_o(div2), .ref2_o(ref2),
    .ctrl_a_o(ctla), .ctrl_b_o(ctlb), .load_o(load)
  );

  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {17'h1A5C3, 3'd1}, {17'h0F0F0, 3'd2}, {17'h15555, 3'd3}, {17'h0AAAA, 3'd4},
    {17'h1FFFF, 3'd5}, {17'h00001, 3'd6}, {17'h12345, 3'd0}, {17'h0BEEF, 3'd7}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i];
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(logic [31:0] v, int n);
    sen = 1'b1;
    tick(4);
    send_bits(v, n);
    tick(4);
    sen = 1'b0;
    tick(8);
  endtask

  task automatic model(logic [19:0] f);
    if (f[2:0] >= 3'd1 && f[2:0] <= 3'd6) expv[f[2:0] - 1] = f[19:3];
  endtask

  task automatic chk_all(string req);
    chk({req, " div1"}, div1, expv[0]);
    chk({req, " ref1"}, ref1, expv[1]);
    chk({req, " div2"}, div2, expv[2]);
    chk({req, " ref2"}, ref2, expv[3]);
    chk({req, " ctla"}, ctla, expv[4]);
    chk({req, " ctlb"}, ctlb, expv[5]);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) expv[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk_all("R1");
    chk("R1 load", {16'd0, load}, 17'd0);

    // R10: first frame with control words zero (power-down)
    frame({12'd0, 17'h0CAFE, 3'd1}, 20);
    model({17'h0CAFE, 3'd1});
    chk("R10 div1 from reset", div1, 17'h0CAFE);

    // R3 R5 R6 R9 vector walk
    foreach (VEC[k]) begin
      frame({12'd0, VEC[k]}, 20);
      model(VEC[k]);
      if (VEC[k][2:0] == 3'd0 || VEC[k][2:0] == 3'd7) chk_all("R6");
      else chk_all("R5 R3 R9");
    end

    // R4: five extra leading ones
    frame({7'd0, 5'b11111, 17'h01357, 3'd4}, 25);
    model({17'h01357, 3'd4});
    chk("R4 ref2", ref2, 17'h01357);
    chk_all("R4");

    // R7: outputs hold mid-frame
    sen = 1'b1;
    tick(4);
    send_bits({12'd0, 17'h1C0DE, 3'd2}, 20);
    tick(4);
    chk("R7 ref1 before enable fall", ref1, expv[1]);
    sen = 1'b0;
    tick(8);
    model({17'h1C0DE, 3'd2});
    chk("R7 ref1 after enable fall", ref1, 17'h1C0DE);

    // R8: strobe through sclk rise, cleared by sclk fall
    chk("R8 load after enable fall", {16'd0, load}, 17'd1);
    sclk = 1'b1;
    tick(8);
    chk("R8 load after sclk rise", {16'd0, load}, 17'd1);
    sclk = 1'b0;
    tick(8);
    chk("R8 load after sclk fall", {16'd0, load}, 17'd0);

    // R2: clocks with enable low are ignored (would retarget to addr 011)
    frame({12'd0, 17'h0D00D, 3'd1}, 20);
    model({17'h0D00D, 3'd1});
    send_bits(32'b011, 3);
    sen = 1'b1;
    tick(8);
    sen = 1'b0;
    tick(8);
    chk("R2 div2 untouched", div2, expv[2]);
    chk("R2 div1 rewritten same", div1, 17'h0D00D);

    // R1: reset mid-use clears all
    rst_n = 1'b0;
    tick(2);
    for (int i = 0; i < 6; i++) expv[i] = '0;
    chk_all("R1 re-reset");
    rst_n = 1'b1;
    tick(4);
    finish_run();
  end
endmodule